// File: doc/BRIEF.md
# Pairwise SIMD Integer Reduction Unit

This unit takes one 32-bit vector instruction word and two 128-bit source operands. It carries out a pairwise integer operation across them: add, signed or unsigned maximum, or signed or unsigned minimum. Both sources are joined into one long vector, with the second source on top. Each adjacent pair of elements in that joined vector collapses into one destination element. The first source therefore supplies the low half of the result, and the second source supplies the high half.

Element widths of 8, 16, 32 and 64 bits are supported, over either a 64-bit or a 128-bit vector width. Encodings that name an illegal combination raise an undefined flag, and in that case the write enable stays low. The result path is combinational. A parameter can add one register stage in front of the outputs.

The unit sits beside a register file that it does not contain. Issue logic reads the two source registers named in the instruction and presents them, together with the word, while `issue` is high. It then writes `res` to the register given by `dst` whenever `wr_en` is high.

Top module: `pair_reduce`

## Requirements
- R1: Field decode: the width select is bit 30 (1 = 128-bit vector), the sign select is bit 29, the element size code is bits 23:22 (0..3 selecting 8, 16, 32 or 64 bits) and the operation code is bits 15:11. Code 0x17 is add, 0x14 is maximum and 0x15 is minimum. Bits 4:0 appear on `dst`.
- R2: Pairwise add wraps modulo the element width at every element size, with no saturation.
- R3: For maximum and minimum, sign select 0 compares elements as two's complement at their own width, and sign select 1 compares them as unsigned magnitudes.
- R4: Result element k is formed from elements 2k and 2k+1 of the joined vector {second, first}. Pairs drawn from the first source fill the low half of the result elements, and pairs drawn from the second source fill the high half.
- R5: With bit 30 = 0, only bits 63:0 of each source are used, and result bits 127:64 are zero.
- R6: Element size code 3 together with bit 30 = 0 raises `undef`.
- R7: Maximum or minimum with element size code 3 raises `undef`. Add at size code 3 with bit 30 = 1 and sign select 0 is legal.
- R8: Add with sign select 1 raises `undef`.
- R9: Any operation code other than 0x14, 0x15 and 0x17 raises `undef`.
- R10: `wr_en` is high only when `issue` is high and the word is legal. `undef` is high only when `issue` is high and the word is illegal. `res` is zero whenever `wr_en` is low.
- R11: With `REG_OUT` = 1, the outputs appear one clock after the inputs that produced them. An active-low reset clears `res`, `wr_en`, `undef` and `dst` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction word is presented this cycle |
| insn | input | 32 | Instruction word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| res | output | 128 | Pairwise result |
| wr_en | output | 1 | Destination write enable |
| undef | output | 1 | Illegal encoding flag |
| dst | output | 5 | Destination register index |

## Verification
The embedded properties assume that `issue` and its operands are steady around each clock edge and that `issue` is held low for as long as reset is asserted. The latency property relies on the second condition. The stimulus drives every input on the falling edge and keeps `issue` low until reset has been released. An exhaustive pass covers every operation code, element size, width select and sign select, which shows each illegal combination at the flag. Random operands, with directed sign-boundary and carry-out values mixed in, then exercise the legal combinations.

// File: rtl/pair_reduce.sv
module pair_reduce #(
  parameter int VW      = 128,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [31:0]   insn,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  output logic [VW-1:0] res,
  output logic          wr_en,
  output logic          undef,
  output logic [4:0]    dst
);
  localparam int HW = VW / 2;
  localparam logic [4:0] OP_MAX = 5'h14;
  localparam logic [4:0] OP_MIN = 5'h15;
  localparam logic [4:0] OP_ADD = 5'h17;

  logic       wide, uns;
  logic [1:0] sz;
  logic [4:0] opc;
  assign wide = insn[30];
  assign uns  = insn[29];
  assign sz   = insn[23:22];
  assign opc  = insn[15:11];

  logic unused_bits;
  assign unused_bits = ^{insn[31], insn[28:24], insn[21:16], insn[10:5]};

  logic illegal, c_wen, c_undef;
  always_comb begin
    illegal = 1'b0;
    if (sz == 2'd3 && !wide) illegal = 1'b1;
    case (opc)
      OP_MAX, OP_MIN: if (sz == 2'd3) illegal = 1'b1;
      OP_ADD:         if (uns)        illegal = 1'b1;
      default:        illegal = 1'b1;
    endcase
  end
  assign c_wen   = issue & ~illegal;
  assign c_undef = issue & illegal;

  logic [2*VW-1:0] cat;
  assign cat = wide ? {src_b, src_a} : {{VW{1'b0}}, src_b[HW-1:0], src_a[HW-1:0]};

  logic [3:0][VW-1:0] lane_res;
  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int E = 8 << s;
    localparam int N = VW / E;
    for (genvar k = 0; k < N; k++) begin : g_el
      logic [E-1:0] x, y, sum;
      logic         lt;
      assign x   = cat[2*k*E +: E];
      assign y   = cat[(2*k+1)*E +: E];
      assign sum = x + y;
      assign lt  = uns ? (x < y) : ($signed(x) < $signed(y));
      assign lane_res[s][k*E +: E] = (opc == OP_ADD) ? sum :
                                     (opc == OP_MAX) ? (lt ? y : x) : (lt ? x : y);
    end
  end

  logic [VW-1:0] c_res;
  assign c_res = c_wen ? lane_res[sz] : '0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res   <= '0;
        wr_en <= 1'b0;
        undef <= 1'b0;
        dst   <= '0;
      end else begin
        res   <= c_res;
        wr_en <= c_wen;
        undef <= c_undef;
        dst   <= insn[4:0];
      end
    end

    // R11
    reg_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (wr_en == $past(c_wen) && undef == $past(c_undef)));
  end else begin : g_comb
    assign res   = c_res;
    assign wr_en = c_wen;
    assign undef = c_undef;
    assign dst   = insn[4:0];
  end

  // R10
  wen_undef_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && undef));

  // R5
  narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wen && !wide) |-> (c_res[VW-1:HW] == '0));

  // R6
  narrow_d64_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && sz == 2'd3 && !wide) |-> c_undef);

  // R4
  add_d64_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wen && sz == 2'd3) |->
      (c_res == {src_b[HW-1:0] + src_b[VW-1:HW], src_a[HW-1:0] + src_a[VW-1:HW]}));
endmodule

// File: tb/tb_pair_reduce.sv
`timescale 1ns/1ps
module tb_pair_reduce;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] src_a = '0, src_b = '0;
  logic [127:0] res;
  logic         wr_en, undef;
  logic [4:0]   dst;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pair_reduce #(.VW(128), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn),
    .src_a(src_a), .src_b(src_b), .res(res), .wr_en(wr_en),
    .undef(undef), .dst(dst));

  function automatic logic [31:0] mk(input bit q, input bit u, input int sz,
                                     input int op, input logic [4:0] rd);
    logic [31:0] w;
    w = $urandom();
    w[30] = q; w[29] = u; w[23:22] = sz[1:0]; w[15:11] = op[4:0]; w[4:0] = rd;
    return w;
  endfunction

  function automatic void model(input logic [31:0] i, input logic [127:0] a, b,
                                output bit bad, output logic [127:0] r);
    int sz, op, esz, nel, j;
    bit q, u, lt;
    logic [63:0] msk, sb, x, y, z;
    logic [127:0] s;
    sz = int'(i[23:22]); op = int'(i[15:11]); q = i[30]; u = i[29];
    bad = !(op == 'h14 || op == 'h15 || op == 'h17) || (sz == 3 && !q) ||
          (op != 'h17 && sz == 3) || (op == 'h17 && u);
    r = '0;
    if (!bad) begin
      esz = 8 << sz;
      nel = (q ? 128 : 64) / esz;
      msk = (esz == 64) ? '1 : ((64'd1 << esz) - 64'd1);
      sb  = 64'd1 << (esz - 1);
      for (int k = 0; k < nel; k++) begin
        s = (k < nel / 2) ? a : b;
        j = (k < nel / 2) ? 2 * k : 2 * (k - nel / 2);
        x = 64'(s >> (j * esz)) & msk;
        y = 64'(s >> ((j + 1) * esz)) & msk;
        lt = u ? (x < y) : ((x ^ sb) < (y ^ sb));
        if (op == 'h17)      z = (x + y) & msk;
        else if (op == 'h14) z = lt ? y : x;
        else                 z = lt ? x : y;
        r = r | (128'(z) << (k * esz));
      end
    end
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [127:0] act, input logic [127:0] exp);
    n_fail++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic run(input string tag, input bit iss, input logic [31:0] w,
                     input logic [127:0] a, input logic [127:0] b);
    bit bad;
    logic [127:0] er;
    logic ew, eu;
    issue = iss; insn = w; src_a = a; src_b = b;
    model(w, a, b, bad, er);
    ew = iss & !bad; eu = iss & bad;
    if (!ew) er = '0;
    @(negedge clk);
    n_chk++;
    if (wr_en !== ew)         fail_line(tag, "wr_en", 128'(wr_en), 128'(ew));
    else if (undef !== eu)    fail_line(tag, "undef", 128'(undef), 128'(eu));
    else if (res !== er)      fail_line(tag, "res", res, er);
    else if (dst !== w[4:0])  fail_line(tag, "dst", 128'(dst), 128'(w[4:0]));
  endtask

  function automatic string tag_of(input int op, input int sz, input bit q, input bit u);
    if (sz == 3 && !q)                 return "R6";
    if (op != 'h14 && op != 'h15 && op != 'h17) return "R9";
    if (op != 'h17 && sz == 3)         return "R7";
    if (op == 'h17 && u)               return "R8";
    if (!q)                            return "R5";
    if (op == 'h17)                    return "R2";
    return "R3";
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int op, sz;
    bit q, u;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    n_chk++;
    if (res !== '0 || wr_en !== 1'b0 || undef !== 1'b0 || dst !== '0)
      fail_line("R11", "reset outputs", res, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: result lands one cycle after drive
    run("R11", 1'b1, mk(1, 0, 2, 'h17, 5'd9), rnd128(), rnd128());
    run("R10", 1'b0, mk(1, 0, 0, 'h17, 5'd3), rnd128(), rnd128());
    run("R10", 1'b0, mk(0, 1, 3, 'h16, 5'd3), rnd128(), rnd128());
    // R2: 8-bit wrap 0xFF + 0x01
    run("R2", 1'b1, mk(1, 0, 0, 'h17, 5'd1), {8{16'h01FF}}, {8{16'h8080}});
    run("R2", 1'b1, mk(1, 0, 1, 'h17, 5'd2), {4{32'hFFFF_0001}}, {4{32'h8000_8000}});
    run("R2", 1'b1, mk(1, 0, 3, 'h17, 5'd2), {64'hFFFF_FFFF_FFFF_FFFF, 64'd1}, {64'd5, 64'd7});
    // R3: 0x80 vs 0x7F flips between signed and unsigned
    run("R3", 1'b1, mk(1, 0, 0, 'h14, 5'd4), {8{16'h807F}}, {8{16'h7F80}});
    run("R3", 1'b1, mk(1, 1, 0, 'h14, 5'd4), {8{16'h807F}}, {8{16'h7F80}});
    run("R3", 1'b1, mk(1, 0, 2, 'h15, 5'd4), {2{64'h8000_0000_7FFF_FFFF}}, rnd128());
    run("R3", 1'b1, mk(1, 1, 2, 'h15, 5'd4), {2{64'h8000_0000_7FFF_FFFF}}, rnd128());
    // R4: distinct element values expose pair order
    run("R4", 1'b1, mk(1, 0, 2, 'h17, 5'd5), {32'd4, 32'd3, 32'd2, 32'd1}, {32'd40, 32'd30, 32'd20, 32'd10});
    // R5: high source halves must be ignored
    run("R5", 1'b1, mk(0, 0, 1, 'h17, 5'd6), {64'hDEAD_BEEF_DEAD_BEEF, 64'h0004_0003_0002_0001}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0040_0030_0020_0010});
    run("R6", 1'b1, mk(0, 0, 3, 'h17, 5'd7), rnd128(), rnd128());
    run("R7", 1'b1, mk(1, 0, 3, 'h14, 5'd7), rnd128(), rnd128());
    run("R7", 1'b1, mk(1, 1, 3, 'h15, 5'd7), rnd128(), rnd128());
    run("R8", 1'b1, mk(1, 1, 2, 'h17, 5'd7), rnd128(), rnd128());
    run("R9", 1'b1, mk(1, 0, 0, 'h16, 5'd7), rnd128(), rnd128());
    run("R1", 1'b1, mk(1, 1, 1, 'h15, 5'd31), rnd128(), rnd128());

    // R1 R9: every opcode, size, width and sign combination
    for (int o = 0; o < 32; o++)
      for (int s = 0; s < 4; s++)
        for (int qq = 0; qq < 2; qq++)
          for (int uu = 0; uu < 2; uu++)
            run(tag_of(o, s, qq[0], uu[0]), 1'b1, mk(qq[0], uu[0], s, o, 5'($urandom())), rnd128(), rnd128());

    for (int n = 0; n < 3000; n++) begin
      case ($urandom_range(0, 3))
        0: op = 'h14;
        1: op = 'h15;
        2: op = 'h17;
        default: op = int'($urandom_range(0, 31));
      endcase
      sz = int'($urandom_range(0, 3));
      q  = 1'($urandom());
      u  = 1'($urandom());
      run(tag_of(op, sz, q, u), ($urandom_range(0, 7) != 0), mk(q, u, sz, op, 5'($urandom())), rnd128(), rnd128());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule